// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flag Unit

This block holds a small set of sticky status flags for a peripheral. A peripheral event raises a flag with a one-cycle pulse. Software lowers the flag with a two-access sequence. It first reads the status register while the flag is high, which arms that flag. It then reads or writes the data register that belongs to that flag. Arming applies only to flags that were seen high by that status read, so an event that arrives after the read survives the next data access.

A debugger can halt the system and then inspect registers freely. While the break input is high and the break clear-enable input is low, no bus access can lower a flag. Status reads also leave the arming state alone, and data accesses do not remove an existing arm. An arm that was made before the halt therefore still completes the clear once the halt ends. When clear-enable is high, clearing works normally during break, and a flag lowered then stays low after break ends. Outside break, the clear-enable input has no effect.

The status register returns the flags in its low bits, one cycle after the read strobe.

Top module: `sflag_guard`

## Requirements
- R1: While `rst` is high at a clock edge, all flags, all arm states and `rdata` become 0 after that edge.
- R2: A high `set_pulse[i]` at a clock edge makes `flags[i]` 1 after that edge.
- R3: A read at address STATUS_ADDR (default 0) loads `rdata` one cycle later with the pre-edge flags in bits [NUM_FLAGS-1:0] and zeros above. Any other read, or no read, loads 0.
- R4: Flag i is lowered by a status read that sees it high, followed later by a read or a write at address DATA_BASE+i (default 1 for flag 0, 2 for flag 1). It is 0 after the edge of the second access, and that access leaves the other flags unchanged.
- R5: A data-register access lowers nothing when no status read saw that flag high since the flag's last clear or reset.
- R6: When a set pulse and a completing second access for the same flag fall on the same edge, the flag stays 1.
- R7: While `brk_active`=1 and `brk_clr_en`=0, no bus access lowers any flag. Status reads leave arm states unchanged, and data accesses keep existing arms.
- R8: An arm made before a protected break still lets the data access that follows the break lower the flag.
- R9: While `brk_active`=1 and `brk_clr_en`=1, the two-step clear works as in R4, and a flag lowered then stays 0 after `brk_active` returns to 0.
- R10: With `brk_active`=0, the value of `brk_clr_en` does not change any flag or arm behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | NUM_FLAGS | Per-flag event pulses |
| brk_active | input | 1 | Debug halt is in progress |
| brk_clr_en | input | 1 | Allows clearing while halted |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| rdata | output | DATA_W | Registered read data |
| flags | output | NUM_FLAGS | Registered flag values |

## Verification
A peripheral set pulse and the second access of a clear sequence can land on the same edge for the same flag. The bench forces this collision both in a directed case and as a random event, with break active and inactive, and requires the flag to read 1 afterwards. A cycle-by-cycle reference model built from the requirements judges every result, including the arm state that carries across break entry and exit, which it observes through later clear attempts.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  // Classification of one bus cycle as seen by a single flag
  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_STATUS = 2'd1,
    ACC_DATA   = 2'd2,
    ACC_OTHER  = 2'd3
  } acc_kind_t;

  typedef struct packed {
    logic flag;
    logic armed;
  } flag_state_t;
endpackage

// File: rtl/sflag_decode.sv
module sflag_decode #(
  parameter int NUM_FLAGS   = 2,
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int DATA_BASE   = 1
) (
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic                 stat_rd,
  output logic [NUM_FLAGS-1:0] data_acc
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

  assign stat_rd = bus_rd && (bus_addr == STAT_A);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_BASE + i);
    assign data_acc[i] = (bus_rd || bus_wr) && (bus_addr == DATA_A);
  end
endmodule

// File: rtl/sflag_cell.sv
module sflag_cell
  import sflag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic protect,
  input  logic stat_rd,
  input  logic data_acc,
  output logic flag,
  output logic armed
);
  flag_state_t st_q, st_d;
  acc_kind_t   kind;
  logic        clr_fire;

  always_comb begin
    if (stat_rd)       kind = ACC_STATUS;
    else if (data_acc) kind = ACC_DATA;
    else               kind = ACC_IDLE;
  end

  // Second step completes only if armed and not protected
  assign clr_fire = (kind == ACC_DATA) && st_q.armed && !protect;

  always_comb begin
    st_d = st_q;
    if (!protect && kind == ACC_STATUS) st_d.armed = st_q.flag;
    if (clr_fire) begin
      st_d.armed = 1'b0;
      st_d.flag  = 1'b0;
    end
    if (set_pulse) st_d.flag = 1'b1;   // event wins over clear
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign flag  = st_q.flag;
  assign armed = st_q.armed;
endmodule

// File: rtl/sflag_readback.sv
module sflag_readback #(
  parameter int NUM_FLAGS = 2,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stat_rd,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [DATA_W-1:0]    rdata
);
  // NUM_FLAGS must not exceed DATA_W
  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (stat_rd) rdata <= DATA_W'(flags);
    else              rdata <= '0;
  end
endmodule

// File: rtl/sflag_guard.sv
module sflag_guard #(
  parameter int NUM_FLAGS   = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 0,
  parameter int DATA_BASE   = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set_pulse,
  input  logic                 brk_active,
  input  logic                 brk_clr_en,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_FLAGS-1:0] flags
);
  logic                 stat_rd;
  logic [NUM_FLAGS-1:0] data_acc;
  logic [NUM_FLAGS-1:0] armed_vec;
  logic                 protect;

  assign protect = brk_active && !brk_clr_en;

  sflag_decode #(
    .NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W),
    .STATUS_ADDR(STATUS_ADDR), .DATA_BASE(DATA_BASE)
  ) u_dec (
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .stat_rd(stat_rd), .data_acc(data_acc)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
    sflag_cell u_cell (
      .clk(clk), .rst(rst), .set_pulse(set_pulse[i]), .protect(protect),
      .stat_rd(stat_rd), .data_acc(data_acc[i]),
      .flag(flags[i]), .armed(armed_vec[i])
    );
  end

  sflag_readback #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .flags(flags), .rdata(rdata)
  );
endmodule

// File: rtl/sflag_guard_chk.sv
module sflag_guard_chk #(
  parameter int NUM_FLAGS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_FLAGS-1:0] set_pulse,
  input logic                 brk_active,
  input logic                 brk_clr_en,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] armed_vec
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags == '0 && armed_vec == '0));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_p
    // R2 and R6: an event always leaves the flag high
    a_r2_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_pulse[i] |=> flags[i]);
    // R5: an unarmed high flag cannot fall
    a_r5_unarmed_holds: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !armed_vec[i]) |=> flags[i]);
    // R7: protected break keeps flags
    a_r7_protect_flag: assert property (@(posedge clk) disable iff (rst)
      (brk_active && !brk_clr_en && flags[i]) |=> flags[i]);
    // R7 and R8: protected break keeps arms
    a_r8_protect_arm: assert property (@(posedge clk) disable iff (rst)
      (brk_active && !brk_clr_en && armed_vec[i]) |=> armed_vec[i]);
    // R4: an arm only exists on a high flag
    a_r4_arm_on_set: assert property (@(posedge clk) disable iff (rst)
      armed_vec[i] |-> flags[i]);
  end
endmodule

bind sflag_guard sflag_guard_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
  .clk(clk), .rst(rst), .set_pulse(set_pulse), .brk_active(brk_active),
  .brk_clr_en(brk_clr_en), .flags(flags), .armed_vec(armed_vec)
);

// File: tb/test_sflag_guard.sv
module test_sflag_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 2;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [NF-1:0] set_pulse;
  logic          brk_active, brk_clr_en, bus_rd, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] rdata;
  logic [NF-1:0] flags;

  int checks = 0;
  int failures = 0;

  logic [NF-1:0] m_flag, m_arm;
  logic [DW-1:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflag_guard i_sflag_guard (
    .clk(clk), .rst(rst), .set_pulse(set_pulse), .brk_active(brk_active),
    .brk_clr_en(brk_clr_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .rdata(rdata), .flags(flags)
  );

  // Reference built from the requirements: status at 0, flag i data at 1+i
  function automatic logic [DW-1:0] exp_rdata(logic rd, logic [AW-1:0] a, logic [NF-1:0] f);
    return (rd && a == 0) ? DW'(f) : '0;
  endfunction

  task automatic model_step();
    logic [NF-1:0] nf, na;
    logic prot;
    prot = brk_active && !brk_clr_en;
    nf = m_flag; na = m_arm;
    for (int i = 0; i < NF; i++) begin
      if (!prot && bus_rd && bus_addr == 0) na[i] = m_flag[i];
      if (!prot && (bus_rd || bus_wr) && bus_addr == AW'(1 + i) && m_arm[i]) begin
        na[i] = 1'b0; nf[i] = 1'b0;
      end
      if (set_pulse[i]) nf[i] = 1'b1;
    end
    m_rdata = exp_rdata(bus_rd, bus_addr, m_flag);
    if (rst) begin nf = '0; na = '0; m_rdata = '0; end
    m_flag = nf; m_arm = na;
  endtask

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic [NF-1:0] s, logic rd, logic wr,
                     logic [AW-1:0] a, logic b, logic en);
    set_pulse = s; bus_rd = rd; bus_wr = wr; bus_addr = a;
    brk_active = b; brk_clr_en = en;
    @(posedge clk);
    model_step();
    #1;
    check(tag, DW'(flags), DW'(m_flag), "flags");
    check(tag, rdata, m_rdata, "rdata");
  endtask

  initial begin
    rst = 1'b1; m_flag = '0; m_arm = '0; m_rdata = '0;
    cyc("R1", 2'b11, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
    cyc("R1", 2'b00, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
    rst = 1'b0;
    // R2, R3, R4 by read
    cyc("R2", 2'b01, 0, 0, 4'd0, 0, 0);
    check("R2", DW'(flags), 8'h01, "flag0 set");
    cyc("R3", 2'b00, 1, 0, 4'd0, 0, 0);
    check("R3", rdata, 8'h01, "status read");
    cyc("R3", 2'b00, 1, 0, 4'd5, 0, 0);
    check("R3", rdata, 8'h00, "other read");
    cyc("R4", 2'b00, 1, 0, 4'd1, 0, 0);
    check("R4", DW'(flags), 8'h00, "clear by read");
    // R4 by write, other flag untouched
    cyc("R4", 2'b11, 0, 0, 4'd0, 0, 0);
    cyc("R4", 2'b00, 1, 0, 4'd0, 0, 0);
    cyc("R4", 2'b00, 0, 1, 4'd2, 0, 0);
    check("R4", DW'(flags), 8'h01, "clear flag1 by write");
    cyc("R4", 2'b00, 0, 1, 4'd1, 0, 0);
    check("R4", DW'(flags), 8'h00, "clear flag0");
    // R5: set after status read is not cleared
    cyc("R5", 2'b00, 1, 0, 4'd0, 0, 0);
    cyc("R5", 2'b01, 0, 0, 4'd0, 0, 0);
    cyc("R5", 2'b00, 1, 0, 4'd1, 0, 0);
    check("R5", DW'(flags), 8'h01, "late set survives");
    // R6: collision of set and second step
    cyc("R6", 2'b00, 1, 0, 4'd0, 0, 0);
    cyc("R6", 2'b01, 1, 0, 4'd1, 0, 0);
    check("R6", DW'(flags), 8'h01, "set beats clear");
    // R7/R8: arm, then protected break
    cyc("R8", 2'b00, 1, 0, 4'd0, 0, 0);
    cyc("R7", 2'b00, 1, 0, 4'd1, 1, 0);
    check("R7", DW'(flags), 8'h01, "read in break keeps flag");
    cyc("R7", 2'b00, 0, 1, 4'd1, 1, 0);
    cyc("R7", 2'b00, 1, 0, 4'd0, 1, 0);
    check("R7", DW'(flags), 8'h01, "write in break keeps flag");
    cyc("R8", 2'b00, 0, 1, 4'd1, 0, 0);
    check("R8", DW'(flags), 8'h00, "arm survives break");
    // R9: clear-enable in break
    cyc("R9", 2'b10, 0, 0, 4'd0, 1, 1);
    cyc("R9", 2'b00, 1, 0, 4'd0, 1, 1);
    cyc("R9", 2'b00, 0, 1, 4'd2, 1, 1);
    check("R9", DW'(flags), 8'h00, "clear in break");
    cyc("R9", 2'b00, 0, 0, 4'd0, 0, 0);
    check("R9", DW'(flags), 8'h00, "stays clear after break");
    // R10: enable ignored outside break
    cyc("R10", 2'b01, 0, 0, 4'd0, 0, 1);
    cyc("R10", 2'b00, 1, 0, 4'd0, 0, 1);
    cyc("R10", 2'b00, 1, 0, 4'd1, 0, 1);
    check("R10", DW'(flags), 8'h00, "normal clear with enable");
    // Random mix, judged against the model each cycle
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [NF-1:0] s;
      logic rd, wr, b, en;
      logic [AW-1:0] a;
      s  = (($urandom % 6) == 0) ? NF'($urandom) : '0;
      rd = ($urandom % 3) == 0;
      wr = !rd && (($urandom % 4) == 0);
      a  = AW'($urandom % 4);
      b  = ($urandom % 4) == 0;
      en = $urandom % 2;
      cyc("R4", s, rd, wr, a, b, en);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule